// File: doc/BRIEF.md
# Multi-Cycle Rotate-Left Unit

This block carries out a rotate-left operation on a 32-bit data register operand. A caller presents a 16-bit shift/rotate opcode word, the operand, a register-sourced count value and the five incoming condition flags, then pulses `start`. The unit decodes the operand size and the rotate count from the opcode and rotates only the sized low portion of the operand: the low byte, the low word or the full long. The bits above that portion are returned untouched.

The unit models the execution time of the instruction. It rotates one bit position every two clock cycles after a fixed set-up time, so `busy` stays high for exactly as many cycles as the instruction takes. In the cycle after `busy` falls it raises `done` for one cycle. In that cycle it presents the merged 32-bit result, the updated flags and the destination register number. Requests that arrive while the unit is busy are dropped.

Top module: `rotl_unit`

## Requirements
- R1: Opcode bit 5 selects the count source. When bit 5 is 1, the count is `count_reg[5:0]`, which is the register value modulo 64. When bit 5 is 0, the count is opcode bits 11:9, and the value 0 there means a count of 8.
- R2: Opcode bits 7:6 select the size: 00 is byte (bits 7:0), 01 is word (bits 15:0), 10 is long (bits 31:0), and 11 is handled as long. The sized portion is rotated left by the count, taken modulo the size width. All bits above the sized portion equal the operand.
- R3: The flags word is laid out as [4]=X (extend), [3]=N (negative), [2]=Z (zero), [1]=V (overflow), [0]=C (carry). C equals bit 0 of the sized result when the count is nonzero. C is 0 when the count is zero.
- R4: N equals the most significant bit of the sized result. Z is 1 exactly when the sized result is zero, whatever Z was on entry.
- R5: V is always 0. X on exit equals X on entry.
- R6: After the clock edge that accepts `start`, `busy` is high for exactly N cycles. N = 6 + 2·count for byte and word, and N = 8 + 2·count for long, where count is the value after R1 (a count of zero included).
- R7: `done` is high for exactly one cycle, namely the cycle right after `busy` falls. `busy` and `done` are never high together. `result` and `ccr_out` are valid while `done` is high.
- R8: A `start` raised while `busy` is high is ignored. Neither the result nor the timing of the operation in progress changes.
- R9: While `done` is high, `dst_reg` equals opcode bits 2:0 of the accepted request.
- R10: After reset, `busy` and `done` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Request pulse; sampled only while idle |
| opcode | input | 16 | Shift/rotate opcode word |
| operand | input | 32 | Destination register contents |
| count_reg | input | 32 | Count-source register contents |
| ccr_in | input | 5 | Flags on entry {X,N,Z,V,C} |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion strobe |
| result | output | 32 | Merged result, valid with done |
| ccr_out | output | 5 | Updated flags {X,N,Z,V,C}, valid with done |
| dst_reg | output | 3 | Destination register number, valid with done |

## Verification
Every size code is swept across all eight immediate count fields. Three operands are used: a mixed pattern, all zeros, and a pattern with only its end bits set. Together they separate a correct rotate from a shift, a wrong lane from a right one, and a stale Z or C from a recomputed one. Register-sourced counts run over 0 to 63 for each size, with junk above bit 5, so that counts of zero, counts of exactly the width, and counts above the width are each seen. The extra test is a second request sent mid-operation with a different operand and opcode; it shows that the request is dropped rather than restarting or corrupting the operation in progress.

// File: rtl/rotl_pkg.sv
// Shared types for the rotate-left unit.
// Assumes a flags word ordered {X,N,Z,V,C} from bit 4 down to bit 0.
package rotl_pkg;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'b00,
        SZ_WORD = 2'b01,
        SZ_LONG = 2'b10
    } size_e;

    typedef struct packed {
        logic x;
        logic n;
        logic z;
        logic v;
        logic c;
    } ccr_t;

endpackage

// File: rtl/rotl_decode.sv
// Opcode decoder: works out the operand size, the rotate count, the latency
// and the destination register number from one opcode word.
// Assumes the register count is already its low CNT_W bits (modulo 2**CNT_W).
module rotl_decode
    import rotl_pkg::*;
#(
    parameter int OPC_W       = 16,
    parameter int CNT_W       = 6,
    parameter int LAT_W       = 8,
    parameter int BASE_SHORT  = 6,
    parameter int BASE_LONG   = 8,
    parameter int CYC_PER_BIT = 2,
    parameter int IMM_LSB     = 9,
    parameter int IMM_W       = 3,
    parameter int SRC_BIT     = 5,
    parameter int SIZE_LSB    = 6,
    parameter int REG_W       = 3
) (
    input  logic [OPC_W-1:0] opcode,
    input  logic [CNT_W-1:0] reg_count,
    output size_e            size,
    output logic [CNT_W-1:0] count,
    output logic [LAT_W-1:0] latency,
    output logic [REG_W-1:0] dst
);

    localparam int IMM_ZERO_MEANS = 1 << IMM_W;

    logic [IMM_W-1:0] imm_field;
    logic [LAT_W-1:0] base_cycles;

    assign imm_field = opcode[IMM_LSB +: IMM_W];
    assign dst       = opcode[REG_W-1:0];

    // Pick the count from the register or the immediate field.
    always_comb begin
        if (opcode[SRC_BIT]) begin
            count = reg_count;
        end else if (imm_field == '0) begin
            count = CNT_W'(IMM_ZERO_MEANS);
        end else begin
            count = CNT_W'(imm_field);
        end
    end

    // Map the two size bits to a size; the unused code behaves as long.
    always_comb begin
        case (opcode[SIZE_LSB +: 2])
            2'b00:   size = SZ_BYTE;
            2'b01:   size = SZ_WORD;
            default: size = SZ_LONG;
        endcase
    end

    // Total busy cycles: set-up time plus a fixed cost per rotated bit.
    always_comb begin
        base_cycles = (size == SZ_LONG) ? LAT_W'(BASE_LONG) : LAT_W'(BASE_SHORT);
        latency     = base_cycles + LAT_W'(CYC_PER_BIT) * LAT_W'(count);
    end

endmodule

// File: rtl/rotl_step.sv
// One-position sized rotate-left. Only the lane selected by size moves;
// bits above the lane pass through. Assumes DATA_W is a multiple of 4.
module rotl_step
    import rotl_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  size_e             size,
    input  logic [DATA_W-1:0] d,
    output logic [DATA_W-1:0] q
);

    localparam int BYTE_W  = DATA_W / 4;
    localparam int N_LANES = 3;

    logic [DATA_W-1:0] lane_q [N_LANES];

    // Build one rotated candidate per lane width (byte, word, long).
    for (genvar i = 0; i < N_LANES; i++) begin : g_lane
        localparam int LW = BYTE_W << i;
        if (LW == DATA_W) begin : g_full
            assign lane_q[i] = {d[LW-2:0], d[LW-1]};
        end else begin : g_part
            assign lane_q[i] = {d[DATA_W-1:LW], d[LW-2:0], d[LW-1]};
        end
    end

    // Select the candidate that matches the operand size.
    always_comb begin
        case (size)
            SZ_BYTE: q = lane_q[0];
            SZ_WORD: q = lane_q[1];
            default: q = lane_q[2];
        endcase
    end

endmodule

// File: rtl/rotl_flags.sv
// Flag generator: derives N, Z and C from the sized portion of a result,
// clears V and passes X through. Assumes DATA_W is a multiple of 4.
module rotl_flags
    import rotl_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  size_e             size,
    input  logic [DATA_W-1:0] d,
    input  logic              x_in,
    input  logic              cnt_zero,
    output ccr_t              ccr
);

    localparam int BYTE_W = DATA_W / 4;
    localparam int WORD_W = DATA_W / 2;

    logic sized_msb;
    logic sized_zero;

    // Look only at the sized lane for sign and zero.
    always_comb begin
        case (size)
            SZ_BYTE: begin
                sized_msb  = d[BYTE_W-1];
                sized_zero = (d[BYTE_W-1:0] == '0);
            end
            SZ_WORD: begin
                sized_msb  = d[WORD_W-1];
                sized_zero = (d[WORD_W-1:0] == '0);
            end
            default: begin
                sized_msb  = d[DATA_W-1];
                sized_zero = (d == '0);
            end
        endcase
    end

    // Assemble the flags word.
    always_comb begin
        ccr.x = x_in;
        ccr.n = sized_msb;
        ccr.z = sized_zero;
        ccr.v = 1'b0;
        ccr.c = cnt_zero ? 1'b0 : d[0];
    end

endmodule

// File: rtl/rotl_unit.sv
// Rotate-left execution unit (top). Accepts a request when idle and counts
// down the instruction's latency. In the trailing 2*count cycles it rotates
// the working value one bit every CYC_PER_BIT cycles, and on the final cycle
// registers the result and flags and strobes done.
// Assumes requests during busy are to be dropped.
module rotl_unit
    import rotl_pkg::*;
#(
    parameter int DATA_W      = 32,
    parameter int OPC_W       = 16,
    parameter int CNT_W       = 6,
    parameter int BASE_SHORT  = 6,
    parameter int BASE_LONG   = 8,
    parameter int CYC_PER_BIT = 2,
    parameter int REG_W       = 3,
    parameter int CCR_W       = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [OPC_W-1:0]  opcode,
    input  logic [DATA_W-1:0] operand,
    input  logic [DATA_W-1:0] count_reg,
    input  logic [CCR_W-1:0]  ccr_in,
    output logic              busy,
    output logic              done,
    output logic [DATA_W-1:0] result,
    output logic [CCR_W-1:0]  ccr_out,
    output logic [REG_W-1:0]  dst_reg
);

    localparam int MAX_LAT = BASE_LONG + CYC_PER_BIT * ((1 << CNT_W) - 1);
    localparam int LAT_W   = $clog2(MAX_LAT + 1);

    size_e             dec_size;
    logic [CNT_W-1:0]  dec_count;
    logic [LAT_W-1:0]  dec_lat;
    logic [REG_W-1:0]  dec_dst;

    size_e             size_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [LAT_W-1:0]  cyc_left;
    logic [DATA_W-1:0] work_q;
    logic              x_q;
    logic [REG_W-1:0]  dst_q;

    logic              accept;
    logic              rot_now;
    logic [DATA_W-1:0] stepped;
    logic [DATA_W-1:0] final_val;
    ccr_t              flags_nx;

    rotl_decode #(
        .OPC_W       (OPC_W),
        .CNT_W       (CNT_W),
        .LAT_W       (LAT_W),
        .BASE_SHORT  (BASE_SHORT),
        .BASE_LONG   (BASE_LONG),
        .CYC_PER_BIT (CYC_PER_BIT),
        .REG_W       (REG_W)
    ) u_dec (
        .opcode    (opcode),
        .reg_count (count_reg[CNT_W-1:0]),
        .size      (dec_size),
        .count     (dec_count),
        .latency   (dec_lat),
        .dst       (dec_dst)
    );

    rotl_step #(
        .DATA_W (DATA_W)
    ) u_step (
        .size (size_q),
        .d    (work_q),
        .q    (stepped)
    );

    rotl_flags #(
        .DATA_W (DATA_W)
    ) u_flags (
        .size     (size_q),
        .d        (final_val),
        .x_in     (x_q),
        .cnt_zero (cnt_q == '0),
        .ccr      (flags_nx)
    );

    // A request is taken only when the unit is idle.
    assign accept = start && !busy;

    // Rotate on every CYC_PER_BIT-th cycle inside the trailing rotate window.
    always_comb begin
        rot_now = (cyc_left < LAT_W'(CYC_PER_BIT) * LAT_W'(cnt_q))
               && ((cyc_left % LAT_W'(CYC_PER_BIT)) == '0);
    end

    // Value that is committed if this is the last cycle.
    assign final_val = rot_now ? stepped : work_q;

    // Sequencer: load the request, count down, step the rotate, commit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy     <= 1'b0;
            done     <= 1'b0;
            cyc_left <= '0;
            cnt_q    <= '0;
            size_q   <= SZ_BYTE;
            work_q   <= '0;
            x_q      <= 1'b0;
            dst_q    <= '0;
            result   <= '0;
            ccr_out  <= '0;
            dst_reg  <= '0;
        end else begin
            done <= 1'b0;
            if (accept) begin
                busy     <= 1'b1;
                work_q   <= operand;
                size_q   <= dec_size;
                cnt_q    <= dec_count;
                cyc_left <= dec_lat - LAT_W'(1);
                x_q      <= ccr_in[CCR_W-1];
                dst_q    <= dec_dst;
            end else if (busy) begin
                if (rot_now) begin
                    work_q <= stepped;
                end
                if (cyc_left == '0) begin
                    busy    <= 1'b0;
                    done    <= 1'b1;
                    result  <= final_val;
                    ccr_out <= flags_nx;
                    dst_reg <= dst_q;
                end else begin
                    cyc_left <= cyc_left - LAT_W'(1);
                end
            end
        end
    end

endmodule

// File: rtl/rotl_unit_chk.sv
// Property checker for rotl_unit, attached by bind. Captures each accepted
// request on its own and checks the handshake, the flags and the timing
// against it. Assumes the default 32-bit data and 16-bit opcode layout.
module rotl_unit_chk #(
    parameter int DATA_W = 32,
    parameter int OPC_W  = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic [OPC_W-1:0]  opcode,
    input logic [DATA_W-1:0] operand,
    input logic [DATA_W-1:0] count_reg,
    input logic [4:0]        ccr_in,
    input logic              busy,
    input logic              done,
    input logic [DATA_W-1:0] result,
    input logic [4:0]        ccr_out
);

    logic [7:0]        lat_cnt;
    logic [7:0]        exp_lat;
    logic [1:0]        sz_cap;
    logic              x_cap;
    logic [DATA_W-1:0] op_cap;
    logic [6:0]        req_cnt;

    // Count of this request worked out independently of the decoder.
    always_comb begin
        if (opcode[5]) req_cnt = {1'b0, count_reg[5:0]};
        else if (opcode[11:9] == 3'd0) req_cnt = 7'd8;
        else req_cnt = {4'd0, opcode[11:9]};
    end

    // Capture each accepted request and count its busy cycles.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lat_cnt <= '0;
            exp_lat <= '0;
            sz_cap  <= '0;
            x_cap   <= 1'b0;
            op_cap  <= '0;
        end else if (start && !busy) begin
            lat_cnt <= '0;
            sz_cap  <= opcode[7:6];
            x_cap   <= ccr_in[4];
            op_cap  <= operand;
            exp_lat <= ((opcode[7] == 1'b0) ? 8'd6 : 8'd8) + {req_cnt, 1'b0};
        end else if (busy) begin
            lat_cnt <= lat_cnt + 8'd1;
        end
    end

    // R7
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R7
    busy_done_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy && done));

    // R5
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !ccr_out[1]);

    // R5
    extend_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ccr_out[4] == x_cap);

    // R6
    latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> lat_cnt == exp_lat);

    // R2
    byte_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && sz_cap == 2'b00) |-> result[DATA_W-1:8] == op_cap[DATA_W-1:8]);

    // R2
    word_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && sz_cap == 2'b01) |-> result[DATA_W-1:16] == op_cap[DATA_W-1:16]);

    // R8
    busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |=> (busy || done));

    // R4
    negative_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ccr_out[3] == ((sz_cap == 2'b00) ? result[7] :
                                (sz_cap == 2'b01) ? result[15] : result[DATA_W-1]));

endmodule

bind rotl_unit rotl_unit_chk #(.DATA_W(DATA_W), .OPC_W(OPC_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .opcode    (opcode),
    .operand   (operand),
    .count_reg (count_reg),
    .ccr_in    (ccr_in),
    .busy      (busy),
    .done      (done),
    .result    (result),
    .ccr_out   (ccr_out)
);

// File: tb/rotl_unit_test.sv
`timescale 1ns/1ps
// Sweeps sizes, immediate and register counts and operands; expected data,
// flags and latency are computed arithmetically in the bench.
module rotl_unit_test;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        start;
    logic [15:0] opcode;
    logic [31:0] operand;
    logic [31:0] count_reg;
    logic [4:0]  ccr_in;
    logic        busy;
    logic        done;
    logic [31:0] result;
    logic [4:0]  ccr_out;
    logic [2:0]  dst_reg;

    int total = 0;
    int bad   = 0;

    always #2.5 clk = ~clk;

    rotl_unit uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .opcode    (opcode),
        .operand   (operand),
        .count_reg (count_reg),
        .ccr_in    (ccr_in),
        .busy      (busy),
        .done      (done),
        .result    (result),
        .ccr_out   (ccr_out),
        .dst_reg   (dst_reg)
    );

    // Record one check; print one FAIL line on a mismatch.
    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
        end
    endtask

    function automatic logic [15:0] mk_opc(input logic [2:0] imm, input logic [1:0] sz,
                                           input logic ir, input logic [2:0] rg);
        return {4'hE, imm, 1'b1, sz, ir, 2'b11, rg};
    endfunction

    // Run one request and compare every output with the arithmetic model.
    task automatic run_op(input logic [15:0] opc, input logic [31:0] v,
                          input logic [31:0] creg, input logic [4:0] fin,
                          input bit poke);
        int c, w, k, n_busy, exp_n;
        logic [31:0] m, s, r, exp_res;
        logic [4:0] exp_f;
        c = opc[5] ? int'(creg[5:0]) : ((opc[11:9] == 0) ? 8 : int'(opc[11:9]));
        w = (opc[7:6] == 2'b00) ? 8 : (opc[7:6] == 2'b01) ? 16 : 32;
        m = (w == 32) ? 32'hFFFF_FFFF : ((32'h1 << w) - 32'h1);
        s = v & m;
        k = c % w;
        r = (k == 0) ? s : (((s << k) | (s >> (w - k))) & m);
        exp_res = (v & ~m) | r;
        exp_f = {fin[4], r[w-1], (r == 32'h0), 1'b0, (c != 0) ? r[0] : 1'b0};
        exp_n = ((w == 32) ? 8 : 6) + 2 * c;

        opcode = opc; operand = v; count_reg = creg; ccr_in = fin; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        n_busy = 0;
        for (int g = 0; g < 400 && !done; g++) begin
            if (busy) n_busy++;
            if (poke && n_busy == 3) begin
                // R8: a second request with different data while busy
                opcode = mk_opc(3'd1, 2'b10, 1'b0, 3'd6);
                operand = ~v; ccr_in = ~fin; start = 1'b1;
            end else begin
                start = 1'b0;
            end
            @(negedge clk);
        end
        start = 1'b0;
        chk(result == exp_res, poke ? "R8" : "R2", "result", result, exp_res);
        chk(ccr_out[0] == exp_f[0], "R3", "carry", {31'd0, ccr_out[0]}, {31'd0, exp_f[0]});
        chk(ccr_out[3:2] == exp_f[3:2], "R4", "n_z", {30'd0, ccr_out[3:2]}, {30'd0, exp_f[3:2]});
        chk(ccr_out[4] == exp_f[4] && ccr_out[1] == 1'b0, "R5", "x_v",
            {27'd0, ccr_out}, {27'd0, exp_f});
        chk(n_busy == exp_n, opc[5] ? "R1" : "R6", "latency", n_busy, exp_n);
        chk(dst_reg == opc[2:0], "R9", "dst", {29'd0, dst_reg}, {29'd0, opc[2:0]});
        @(negedge clk);
        chk(!done && !busy, "R7", "done_one_cycle", {30'd0, done, busy}, 32'd0);
    endtask

    // Watchdog: a hung run is a failure and still reaches the summary.
    initial begin
        repeat (190000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog act=%h exp=%h", 1, 0);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [31:0] ops [3];
        ops[0] = 32'hCE3D_D567; ops[1] = 32'h0000_0000; ops[2] = 32'h8000_0001;
        rst_n = 1'b0; start = 1'b0; opcode = '0; operand = '0; count_reg = '0; ccr_in = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10: idle after reset
        chk(!busy && !done, "R10", "reset", {30'd0, busy, done}, 32'd0);

        // R1 R2 R6: immediate counts over every size code and field value
        for (int sz = 0; sz < 4; sz++)
            for (int im = 0; im < 8; im++)
                for (int o = 0; o < 3; o++)
                    run_op(mk_opc(3'(im), 2'(sz), 1'b0, 3'(o + im)), ops[o],
                           32'hFFFF_FFFF, (o == 1) ? 5'h1F : 5'h0A, 1'b0);

        // R1 R3: register counts 0..63 with junk above bit 5
        for (int sz = 0; sz < 3; sz++)
            for (int c = 0; c < 64; c++)
                run_op(mk_opc(3'd5, 2'(sz), 1'b1, 3'd2), ops[0],
                       32'hABCD_0000 | 32'(c) | ((c % 2 == 1) ? 32'h40 : 32'h0),
                       (c % 3 == 0) ? 5'h1F : 5'h04, 1'b0);

        // R8: request during busy is dropped
        run_op(mk_opc(3'd3, 2'b00, 1'b0, 3'd4), 32'h1234_5681, 32'h0, 5'h10, 1'b1);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule